// File: doc/BRIEF.md
# Trio Polarity Symbol Decoder

This block turns the receive side of a three-wire trio link back into base-5 symbols. Three comparators outside the block report the signs of A-B, B-C and C-A. A clock recovery unit, also outside the block, strobes the sampled triplet in. Amplitude is never looked at, because the level spread only exists to force a transition in every unit interval. The polarity triplet is resolved to one of six wire states, and the move from the previously held state to the new one is translated into a symbol between 0 and 4.

Internally a wire state is a phase (0, 1 or 2) plus a sign. The phase names the wire pair that is driven apart. The sign tells which wire of that pair is the higher one. A transition that stays on the same phase flips the sign. Any other transition rotates the phase forward or backward and either keeps or inverts the sign. The decoder is the exact inverse of a transmit encoder that uses the same flip/rotate/polarity convention.

Top module: `trio_symbol_decoder`

## Requirements
- R1: While `rst_n` is low, and after it is released, `sym_vld`, `err_badcode` and `err_stuck` are 0 until a strobe produces an event.
- R2: Polarity bits are `smp_pol[2]`=A>B, `smp_pol[1]`=B>C, `smp_pol[0]`=C>A. In a legal triplet exactly one bit differs from the other two. Its position gives the phase: bit 2 gives phase 0, bit 1 gives phase 1 and bit 0 gives phase 2. Its value gives the sign.
- R3: The first legal sample after reset or after `resync` only loads the history. It raises no output.
- R4: A legal sample with the same phase and the opposite sign of the held state yields symbol 4.
- R5: A legal sample whose phase is the held phase plus one, modulo 3, yields symbol 2 if the sign is unchanged and symbol 3 if the sign is inverted.
- R6: A legal sample whose phase is the held phase minus one, modulo 3, yields symbol 0 if the sign is unchanged and symbol 1 if the sign is inverted.
- R7: Triplets 3'b000 and 3'b111 pulse `err_badcode` for one cycle. They give no symbol and leave both the history and the primed condition untouched.
- R8: A legal sample equal to the held state pulses `err_stuck` for one cycle and gives no symbol.
- R9: Each output event appears in the cycle after the strobe that caused it. Cycles without a strobe raise no output.
- R10: `resync` pulses no output and discards the history, so the next legal sample only primes.
- R11: After each delivered symbol, the received state becomes the history, so consecutive symbols chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| resync | input | 1 | Discard history; next sample primes |
| smp_vld | input | 1 | Sample strobe from clock recovery |
| smp_pol | input | 3 | Comparator signs {A>B, B>C, C>A} |
| sym_vld | output | 1 | Symbol valid pulse |
| sym_val | output | 3 | Recovered symbol 0..4 |
| err_badcode | output | 1 | Impossible triplet received |
| err_stuck | output | 1 | No transition between samples |

## Verification
A corrupted history register shows up on the very next symbol. The held state is the reference for every decode, so a wrong held state makes the next symbol value wrong one cycle after its strobe. A wrong primed flag shows up as a symbol after reset or resync where none should appear, or as a missing one. Bad codes are followed by a legal sample whose symbol reveals whether the history was disturbed. All thirty ordered state pairs are decoded, each from a freshly primed start, so any swapped entry in the transition mapping shows up as a wrong symbol value.

// File: rtl/trio_sym_pkg.sv
package trio_sym_pkg;
  localparam int POL_W   = 3;
  localparam int PH_W    = 2;
  localparam int SYM_W   = 3;
  localparam int N_PHASE = 3;
  localparam logic [SYM_W-1:0] SYM_FLIP = SYM_W'(4);

  typedef struct packed {
    logic [PH_W-1:0] phase;
    logic            sign;
  } wstate_t;
endpackage

// File: rtl/trio_state_map.sv
module trio_state_map
  import trio_sym_pkg::*;
(
  input  logic [POL_W-1:0] pol,
  output wstate_t          st,
  output logic             legal
);
  logic [POL_W-1:0] odd_bit;

  always_comb begin
    legal    = (pol != '0) && (pol != '1);
    // a single 1 among three bits gives odd parity; that bit is the odd one
    st.sign  = ^pol;
    odd_bit  = st.sign ? pol : ~pol;
    if (odd_bit[2])      st.phase = PH_W'(0);
    else if (odd_bit[1]) st.phase = PH_W'(1);
    else                 st.phase = PH_W'(2);
  end
endmodule

// File: rtl/trio_xition_decode.sv
module trio_xition_decode
  import trio_sym_pkg::*;
(
  input  wstate_t          prev_st,
  input  wstate_t          cur_st,
  output logic [SYM_W-1:0] sym,
  output logic             same
);
  logic [PH_W:0] diff_raw;
  logic [PH_W:0] diff;
  logic          fwd;
  logic          pol_chg;

  always_comb begin
    same     = (prev_st == cur_st);
    diff_raw = {1'b0, cur_st.phase} + (PH_W+1)'(N_PHASE) - {1'b0, prev_st.phase};
    diff     = (diff_raw >= (PH_W+1)'(N_PHASE)) ? diff_raw - (PH_W+1)'(N_PHASE) : diff_raw;
    fwd      = (diff == (PH_W+1)'(1));
    pol_chg  = prev_st.sign ^ cur_st.sign;
    if (diff == '0) sym = SYM_FLIP;
    else            sym = {1'b0, fwd, pol_chg};
  end
endmodule

// File: rtl/trio_symbol_decoder.sv
module trio_symbol_decoder
  import trio_sym_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             resync,
  input  logic             smp_vld,
  input  logic [POL_W-1:0] smp_pol,
  output logic             sym_vld,
  output logic [SYM_W-1:0] sym_val,
  output logic             err_badcode,
  output logic             err_stuck
);
  wstate_t          cur_st;
  logic             cur_legal;
  wstate_t          prev_q, prev_d;
  logic             primed_q, primed_d;
  logic [SYM_W-1:0] dec_sym;
  logic             dec_same;
  logic             vld_d, bad_d, stuck_d;
  logic             hist_en;

  trio_state_map u_map (
    .pol   (smp_pol),
    .st    (cur_st),
    .legal (cur_legal)
  );

  trio_xition_decode u_dec (
    .prev_st (prev_q),
    .cur_st  (cur_st),
    .sym     (dec_sym),
    .same    (dec_same)
  );

  // next-state logic
  always_comb begin
    primed_d = primed_q;
    prev_d   = prev_q;
    hist_en  = 1'b0;
    vld_d    = 1'b0;
    bad_d    = 1'b0;
    stuck_d  = 1'b0;
    if (resync) begin
      primed_d = 1'b0;
    end else if (smp_vld) begin
      if (!cur_legal) begin
        bad_d = 1'b1;
      end else if (!primed_q) begin
        primed_d = 1'b1;
        prev_d   = cur_st;
        hist_en  = 1'b1;
      end else if (dec_same) begin
        stuck_d = 1'b1;
      end else begin
        vld_d   = 1'b1;
        prev_d  = cur_st;
        hist_en = 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q    <= 1'b0;
      sym_vld     <= 1'b0;
      err_badcode <= 1'b0;
      err_stuck   <= 1'b0;
    end else begin
      primed_q    <= primed_d;
      sym_vld     <= vld_d;
      err_badcode <= bad_d;
      err_stuck   <= stuck_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else if (hist_en) begin
      prev_q <= prev_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_val <= '0;
    end else if (vld_d) begin
      sym_val <= dec_sym;
    end
  end

  // R1 / R7 / R8: at most one event per cycle
  a_r1_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sym_vld, err_badcode, err_stuck}));

  // R9: every event traces back to a strobe one cycle earlier
  a_r9_event_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_vld || err_badcode || err_stuck) |-> ($past(smp_vld) && !$past(resync)));

  // R7: bad code flag only for the two impossible triplets
  a_r7_badcode_source: assert property (@(posedge clk) disable iff (!rst_n)
    err_badcode |-> ($past(smp_pol) == 3'b000 || $past(smp_pol) == 3'b111));

  // R3: a symbol needs an already primed history
  a_r3_symbol_after_prime: assert property (@(posedge clk) disable iff (!rst_n)
    sym_vld |-> $past(primed_q));

  // R8: stuck flag needs a primed history
  a_r8_stuck_after_prime: assert property (@(posedge clk) disable iff (!rst_n)
    err_stuck |-> $past(primed_q));

  // R4 / R5 / R6: symbol range
  a_r5_symbol_range: assert property (@(posedge clk) disable iff (!rst_n)
    sym_vld |-> (sym_val <= SYM_FLIP));

  // R10: resync leaves the block unprimed
  a_r10_resync_unprimes: assert property (@(posedge clk) disable iff (!rst_n)
    $past(resync) |-> !primed_q);
endmodule

// File: tb/sim_trio_symbol_decoder.sv
module sim_trio_symbol_decoder;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       resync;
  logic       smp_vld;
  logic [2:0] smp_pol;
  logic       sym_vld;
  logic [2:0] sym_val;
  logic       err_badcode;
  logic       err_stuck;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  trio_symbol_decoder u0 (
    .clk(clk), .rst_n(rst_n), .resync(resync), .smp_vld(smp_vld),
    .smp_pol(smp_pol), .sym_vld(sym_vld), .sym_val(sym_val),
    .err_badcode(err_badcode), .err_stuck(err_stuck)
  );

  // R2: odd bit at position 2-phase, carrying the sign
  function automatic logic [2:0] pol_of(int ph, bit s);
    logic [2:0] v;
    v = s ? 3'b000 : 3'b111;
    v[2-ph] = s;
    return v;
  endfunction

  function automatic logic [2:0] exp_sym(int ph0, bit s0, int ph1, bit s1);
    bit r;
    if (ph0 == ph1) return 3'd4;
    r = (ph1 == (ph0 + 1) % 3);
    return {1'b0, r, s0 ^ s1};
  endfunction

  task automatic check(string req, bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // drive one strobe at a falling edge, observe result one full cycle later
  task automatic send(logic [2:0] p);
    @(negedge clk);
    smp_vld = 1'b1;
    smp_pol = p;
    @(negedge clk);
    smp_vld = 1'b0;
  endtask

  task automatic do_resync();
    @(negedge clk);
    resync = 1'b1;
    @(negedge clk);
    resync = 1'b0;
    check("R10", {sym_vld, err_badcode, err_stuck} == 3'b000, "resync event",
          {sym_vld, err_badcode, err_stuck}, 0);
  endtask

  task automatic expect_quiet(string req);
    check(req, {sym_vld, err_badcode, err_stuck} == 3'b000, "quiet {vld,bad,stuck}",
          {sym_vld, err_badcode, err_stuck}, 0);
  endtask

  task automatic expect_sym(string req, logic [2:0] e);
    check(req, sym_vld && !err_badcode && !err_stuck, "sym_vld", sym_vld, 1);
    check(req, sym_val == e, "sym_val", sym_val, e);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; resync = 1'b0; smp_vld = 1'b0; smp_pol = 3'b000;
    repeat (3) @(negedge clk);
    expect_quiet("R1");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    expect_quiet("R1");
  endtask

  task automatic t_prime();
    send(pol_of(0, 1'b1));
    expect_quiet("R3");
    send(pol_of(1, 1'b1));
    expect_sym("R5", 3'd2);
  endtask

  // all thirty ordered pairs, each from a fresh prime (R4 R5 R6 R10)
  task automatic t_all_pairs();
    for (int a = 0; a < 6; a++) begin
      for (int b = 0; b < 6; b++) begin
        if (a != b) begin
          do_resync();
          send(pol_of(a / 2, a[0]));
          expect_quiet("R10");
          send(pol_of(b / 2, b[0]));
          if (a / 2 == b / 2)                 expect_sym("R4", exp_sym(a/2, a[0], b/2, b[0]));
          else if (b / 2 == (a / 2 + 1) % 3)  expect_sym("R5", exp_sym(a/2, a[0], b/2, b[0]));
          else                                expect_sym("R6", exp_sym(a/2, a[0], b/2, b[0]));
        end
      end
    end
  endtask

  task automatic t_chain();
    int ph = 0; bit s = 1'b0;
    int seq_ph[8] = '{2, 2, 0, 1, 0, 2, 1, 1};
    bit seq_s[8]  = '{0, 1, 1, 0, 0, 1, 1, 0};
    do_resync();
    send(pol_of(ph, s));
    for (int i = 0; i < 8; i++) begin
      send(pol_of(seq_ph[i], seq_s[i]));
      expect_sym("R11", exp_sym(ph, s, seq_ph[i], seq_s[i]));
      ph = seq_ph[i]; s = seq_s[i];
    end
  endtask

  task automatic t_badcode();
    do_resync();
    send(3'b111);
    check("R7", err_badcode && !sym_vld, "err_badcode on 111", err_badcode, 1);
    send(pol_of(1, 1'b0));
    expect_quiet("R7");
    send(3'b000);
    check("R7", err_badcode && !sym_vld, "err_badcode on 000", err_badcode, 1);
    @(negedge clk);
    check("R7", !err_badcode, "err_badcode pulse width", err_badcode, 0);
    send(pol_of(2, 1'b0));
    expect_sym("R7", exp_sym(1, 1'b0, 2, 1'b0));
  endtask

  task automatic t_stuck();
    send(pol_of(2, 1'b0));
    check("R8", err_stuck && !sym_vld, "err_stuck", err_stuck, 1);
    @(negedge clk);
    check("R8", !err_stuck, "err_stuck pulse width", err_stuck, 0);
    send(pol_of(1, 1'b1));
    expect_sym("R8", exp_sym(2, 1'b0, 1, 1'b1));
  endtask

  task automatic t_latency();
    @(negedge clk);
    smp_vld = 1'b1; smp_pol = pol_of(1, 1'b0);
    #1;
    check("R9", !sym_vld, "sym_vld before edge", sym_vld, 0);
    @(negedge clk);
    smp_vld = 1'b0;
    expect_sym("R9", exp_sym(1, 1'b1, 1, 1'b0));
    smp_pol = pol_of(0, 1'b0);
    repeat (4) @(negedge clk);
    expect_quiet("R9");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_prime();
    t_all_pairs();
    t_chain();
    t_badcode();
    t_stuck();
    t_latency();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule